// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control core of a multi-channel successive-approximation converter that sits on a microprocessor-style parallel bus. The host writes a control byte with an active-low write strobe qualified by chip select. The block keeps the input-selection and power fields, and it drives the channel multiplexer selects, a unipolar flag, the clock-source choice and a power state. It then runs the sampler through tracking, hold and a fixed-length conversion. In the conversion, a trial code goes out to a comparator, and one bit decision per cycle comes back, MSB first.

Acquisition can be timed in two ways. In the first, the block times it internally for a fixed number of clocks. In the second, the host ends it with a second write whose selection fields must match the first. A new write always aborts the work in progress. When a result is ready, an active-low interrupt falls. A read or a new write releases it. The result comes out in two bytes on an 8-bit tri-state bus.

All host strobes are sampled on `clk`. A write takes effect on the clock edge that first sees the chip-select-and-write combination released, which is the rising edge of the write strobe. The data byte is the one present while the strobe was active.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control byte layout: bits 7:6 power code, bit 5 acquisition-by-host flag, bit 4 single-ended flag, bit 3 unipolar flag, bits 2:0 channel address. `uni_mode` follows bit 3 and `pwr_state` follows bits 7:6 of the last write. A write takes effect on the rising edge of `wr_n` while `cs_n` is low.
- R2: With bit 4 = 1, `mux_pos` is the address and `neg_com` is 1. With bit 4 = 0, `neg_com` is 0, `mux_pos` is the address and `mux_neg` is the address with bit 0 inverted, which gives the pairs 0/1, 2/3, 4/5 and 6/7.
- R3: With bit 5 = 0, `track` is high for exactly 3 clock cycles starting at the write edge. Then `hold` goes high and the conversion starts.
- R4: With bit 5 = 1, `track` stays high until the next write. If that write has bit 5 = 0 and a normal power code, the conversion starts on its own write edge.
- R5: On that second write, `conv_bad` is set if bits 4:0 differ from the first write. A change in bits 7:6 alone leaves it clear. Every other write clears it.
- R6: A conversion lasts 13 cycles. For the first 10 cycles, `dac_trial` is the bits decided so far with the bit under test set, and `cmp_bit` = 1 keeps that bit. At the end, `int_n` falls and the 10-bit code becomes the readable result.
- R7: A write during acquisition or conversion aborts it. No interrupt comes from the aborted work, and a new acquisition begins.
- R8: `int_n` returns high on the first clock of a read (`cs_n` and `rd_n` both low) or on any write.
- R9: Power codes: 00 full power-down, 01 standby, 10 normal with internal clock, 11 normal with external clock. Under 00 or 01, `track` and `hold` stay low and nothing starts until a normal code is written.
- R10: `clk_int` is 0 after reset. A code of 10 sets it to 1 and a code of 11 clears it. The power-down codes leave it unchanged.
- R11: While `cs_n` and `rd_n` are both low, `dout` shows result bits 7:0 when `hben` = 0, and result bits 9:8 zero-extended when `hben` = 1. At all other times `dout` is high-impedance.
- R12: After reset, `track`, `hold` and `conv_bad` are 0, `int_n` is 1, `pwr_state` is 11 and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | Selects the high result byte when 1 |
| din | input | 8 | Control byte from the host |
| dout | output | 8 | Result byte, high-impedance when not read |
| int_n | output | 1 | Active-low result-ready interrupt |
| cmp_bit | input | 1 | Comparator decision for the current trial |
| dac_trial | output | 10 | Trial code for the comparator |
| track | output | 1 | Sampler in tracking |
| hold | output | 1 | Sampler in hold, conversion running |
| mux_pos | output | 3 | Positive input channel select |
| mux_neg | output | 3 | Negative input channel select in pseudo-differential mode |
| neg_com | output | 1 | Negative input tied to the common pin |
| uni_mode | output | 1 | Unipolar coding selected |
| clk_int | output | 1 | Internal clock source selected |
| pwr_state | output | 2 | Current power code |
| conv_bad | output | 1 | Second write changed the selection fields |

## Verification
The assertions take several things for granted. Host strobes are already synchronous to `clk`. A write strobe stays low for at least one clock. Read and write are never active together. `cmp_bit` settles within the same cycle as `dac_trial`.

The bench drives every strobe on the falling clock edge. It holds each write for one full cycle, and it never overlaps a read with a write. It derives `cmp_bit` combinationally from a target code and `dac_trial`, so the expected result is the target itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // control byte field positions; neighbours decode these bits
   localparam int CB_PWR_HI = 7;
   localparam int CB_PWR_LO = 6;
   localparam int CB_HOSTACQ = 5;
   localparam int CB_SGL = 4;
   localparam int CB_UNI = 3;
   localparam int SEL_W = 5;          // bits 4:0 must match on a second write
   localparam logic [1:0] PWR_RST = 2'b11;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ACQI = 2'd1,
      S_ACQX = 2'd2,
      S_CONV = 2'd3
   } seq_state_t;
endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
   import adc_seq_pkg::*;
#(
   parameter int N_CH = 8,
   localparam int AW = $clog2(N_CH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic          rd_n,
   input  logic [7:0]    din,
   output logic          wr_evt,
   output logic          rd_act,
   output logic [7:0]    wr_byte,
   output logic [SEL_W-1:0] sel_q,
   output logic [AW-1:0] mux_pos,
   output logic [AW-1:0] mux_neg,
   output logic          neg_com,
   output logic          uni_mode,
   output logic          clk_int,
   output logic [1:0]    pwr_state
);
   generate
      if (N_CH < 2 || N_CH > 8 || (1 << AW) != N_CH) begin : g_bad_nch
         $error("N_CH must be 2, 4 or 8");
      end
   endgenerate

   logic       wr_act, wr_act_q;
   logic [7:0] din_q;
   logic [AW-1:0] addr;

   assign wr_act  = !cs_n && !wr_n;
   assign rd_act  = !cs_n && !rd_n;
   assign wr_evt  = wr_act_q && !wr_act;
   assign wr_byte = din_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q  <= 1'b0;
         din_q     <= '0;
         sel_q     <= '0;
         pwr_state <= PWR_RST;
         clk_int   <= 1'b0;
      end else begin
         wr_act_q <= wr_act;
         if (wr_act) din_q <= din;
         if (wr_evt) begin
            sel_q     <= din_q[SEL_W-1:0];
            pwr_state <= din_q[CB_PWR_HI:CB_PWR_LO];
            if (din_q[CB_PWR_HI]) clk_int <= !din_q[CB_PWR_LO];
         end
      end
   end

   assign addr     = sel_q[AW-1:0];
   assign mux_pos  = addr;
   assign mux_neg  = addr ^ AW'(1);
   assign neg_com  = sel_q[CB_SGL];
   assign uni_mode = sel_q[CB_UNI];

   // R10
   pd_keeps_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && !wr_byte[CB_PWR_HI]) |=> $stable(clk_int));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int ACQ_CYC = 3,
   parameter int CONV_CYC = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_evt,
   input  logic             rd_act,
   input  logic             wr_norm,
   input  logic             wr_hostacq,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [SEL_W-1:0] sel_q,
   input  logic             run_ok,
   input  logic             cmp_bit,
   output logic [RES_W-1:0] dac_trial,
   output logic [RES_W-1:0] res_q,
   output logic             track,
   output logic             hold,
   output logic             int_n,
   output logic             conv_bad
);
   localparam int CMAX = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
   localparam int CW = $clog2(CMAX + 1);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   generate
      if (CONV_CYC <= RES_W) begin : g_bad_conv
         $error("CONV_CYC must exceed RES_W");
      end
      if (ACQ_CYC < 1) begin : g_bad_acq
         $error("ACQ_CYC must be at least 1");
      end
   endgenerate

   seq_state_t       st;
   logic [CW-1:0]    cnt;
   logic [RES_W-1:0] sar, bit_mask;
   logic             in_dec, acq_end, conv_end;

   assign in_dec    = (st == S_CONV) && (cnt < CW'(RES_W));
   assign bit_mask  = in_dec ? (TOP_BIT >> cnt) : '0;
   assign dac_trial = sar | bit_mask;
   assign acq_end   = (st == S_ACQI) && (cnt == CW'(ACQ_CYC - 1));
   assign conv_end  = (st == S_CONV) && (cnt == CW'(CONV_CYC - 1));
   assign track     = (st == S_ACQI) || (st == S_ACQX);
   assign hold      = (st == S_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         sar      <= '0;
         res_q    <= '0;
         int_n    <= 1'b1;
         conv_bad <= 1'b0;
      end else if (wr_evt) begin
         int_n    <= 1'b1;
         cnt      <= '0;
         sar      <= '0;
         conv_bad <= 1'b0;
         if (!wr_norm)
            st <= S_IDLE;
         else if (st == S_ACQX && !wr_hostacq) begin
            st       <= S_CONV;
            conv_bad <= (wr_sel != sel_q);
         end else if (wr_hostacq)
            st <= S_ACQX;
         else
            st <= S_ACQI;
      end else begin
         case (st)
            S_ACQI: begin
               if (acq_end) begin
                  st  <= S_CONV;
                  cnt <= '0;
               end else cnt <= cnt + CW'(1);
            end
            S_CONV: begin
               if (in_dec && cmp_bit) sar <= dac_trial;
               if (conv_end) begin
                  st    <= S_IDLE;
                  cnt   <= '0;
                  res_q <= sar;
               end else cnt <= cnt + CW'(1);
            end
            default: ;
         endcase
         if (conv_end) int_n <= 1'b0;
         else if (rd_act) int_n <= 1'b1;
      end
   end

   // R3
   acq_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ACQI) |-> (cnt < CW'(ACQ_CYC)));
   // R6
   int_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> $past(hold));
   // R8
   wr_clears_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> int_n);
   // R8
   rd_clears_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && !hold && !wr_evt) |=> int_n);
   // R9
   pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_ok |-> (!track && !hold));
endmodule

// File: rtl/adc_seq_rdport.sv
module adc_seq_rdport #(
   parameter int RES_W = 10,
   parameter int BUS_W = 8
) (
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             hben,
   input  logic [RES_W-1:0] res_q,
   output logic [BUS_W-1:0] dout
);
   logic [BUS_W-1:0] lo_word, hi_word;

   generate
      if (RES_W > 2 * BUS_W) begin : g_bad_bus
         $error("result must fit in two bus words");
      end
      if (RES_W > BUS_W) begin : g_two_word
         assign lo_word = res_q[BUS_W-1:0];
         assign hi_word = BUS_W'(res_q[RES_W-1:BUS_W]);
      end else begin : g_one_word
         assign lo_word = BUS_W'(res_q);
         assign hi_word = '0;
      end
   endgenerate

   assign dout = (!cs_n && !rd_n) ? (hben ? hi_word : lo_word) : {BUS_W{1'bz}};
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int N_CH = 8,
   parameter int RES_W = 10,
   parameter int BUS_W = 8,
   parameter int ACQ_CYC = 3,
   parameter int CONV_CYC = 13,
   localparam int AW = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             hben,
   input  logic [7:0]       din,
   output logic [BUS_W-1:0] dout,
   output logic             int_n,
   input  logic             cmp_bit,
   output logic [RES_W-1:0] dac_trial,
   output logic             track,
   output logic             hold,
   output logic [AW-1:0]    mux_pos,
   output logic [AW-1:0]    mux_neg,
   output logic             neg_com,
   output logic             uni_mode,
   output logic             clk_int,
   output logic [1:0]       pwr_state,
   output logic             conv_bad
);
   logic             wr_evt, rd_act;
   logic [7:0]       wr_byte;
   logic [SEL_W-1:0] sel_q;
   logic [RES_W-1:0] res_q;

   adc_seq_ctl #(.N_CH(N_CH)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .din(din), .wr_evt(wr_evt), .rd_act(rd_act), .wr_byte(wr_byte),
      .sel_q(sel_q), .mux_pos(mux_pos), .mux_neg(mux_neg),
      .neg_com(neg_com), .uni_mode(uni_mode), .clk_int(clk_int),
      .pwr_state(pwr_state)
   );

   adc_seq_fsm #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_act(rd_act),
      .wr_norm(wr_byte[CB_PWR_HI]), .wr_hostacq(wr_byte[CB_HOSTACQ]),
      .wr_sel(wr_byte[SEL_W-1:0]), .sel_q(sel_q), .run_ok(pwr_state[1]),
      .cmp_bit(cmp_bit), .dac_trial(dac_trial), .res_q(res_q),
      .track(track), .hold(hold), .int_n(int_n), .conv_bad(conv_bad)
   );

   adc_seq_rdport #(.RES_W(RES_W), .BUS_W(BUS_W)) u_rd (
      .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .res_q(res_q), .dout(dout)
   );
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
   logic [7:0] din = '0;
   wire  [7:0] dout;
   logic int_n, cmp_bit, track, hold, neg_com, uni_mode, clk_int, conv_bad;
   logic [9:0] dac_trial, target = '0;
   logic [2:0] mux_pos, mux_neg;
   logic [1:0] pwr_state;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign cmp_bit = (target >= dac_trial);

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .hben(hben), .din(din), .dout(dout), .int_n(int_n), .cmp_bit(cmp_bit),
      .dac_trial(dac_trial), .track(track), .hold(hold), .mux_pos(mux_pos),
      .mux_neg(mux_neg), .neg_com(neg_com), .uni_mode(uni_mode),
      .clk_int(clk_int), .pwr_state(pwr_state), .conv_bad(conv_bad)
   );

   function automatic logic [7:0] lo_exp(input logic [9:0] v);
      return v[7:0];
   endfunction
   function automatic logic [7:0] hi_exp(input logic [9:0] v);
      return {6'b0, v[9:8]};
   endfunction
   function automatic logic [7:0] mk_byte(input logic [1:0] pw, input logic ha,
                                         input logic sg, input logic un,
                                         input logic [2:0] ad);
      return {pw, ha, sg, un, ad};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; din = b;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd(input logic hb, output logic [7:0] v);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; hben = hb;
      #(CLK_PERIOD/4) v = dout;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic read_result(input string req, input logic [9:0] exp);
      logic [7:0] v;
      rd(1'b0, v); chk({req, " R11 low byte"}, v, lo_exp(exp));
      rd(1'b1, v); chk({req, " R11 high byte"}, v, hi_exp(exp));
      chk("R8 int released by read", int_n, 1);
      #1 chk("R11 bus idle z", dout, 8'hzz);
   endtask

   // internal acquisition: returns on the cycle int_n falls
   task automatic conv_int(input logic [7:0] b);
      wr(b);
      chk("R3 track at write", {track, hold}, 2'b10);
      tick(2);
      chk("R3 track third cycle", {track, hold}, 2'b10);
      tick(1);
      chk("R3 hold after 3 cycles", {track, hold}, 2'b01);
      tick(12);
      chk("R6 int high before cycle 13", int_n, 1);
      tick(1);
      chk("R6 int low after 13 cycles", {int_n, hold}, 2'b00);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] b;
      void'($urandom(32'h5eed));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R12 reset state
      chk("R12 reset track/hold", {track, hold, conv_bad}, 3'b000);
      chk("R12 reset int_n", int_n, 1);
      chk("R12 reset pwr", pwr_state, 2'b11);
      chk("R10 reset clk_int", clk_int, 0);
      read_result("R12 reset result", 10'd0);

      // directed internal conversions at code extremes
      target = 10'h3ff;
      conv_int(mk_byte(2'b11, 0, 1, 1, 3'd7));
      read_result("R6 full scale", 10'h3ff);
      target = 10'h000;
      conv_int(mk_byte(2'b11, 0, 0, 0, 3'd2));
      read_result("R6 zero", 10'h000);
      chk("R2 pseudo pair neg", mux_neg, 3'd3);

      // R4 host-ended acquisition, power bits change only
      target = 10'h2a5;
      wr(mk_byte(2'b11, 1, 1, 1, 3'd5));
      tick(20);
      chk("R4 track held indefinitely", {track, hold}, 2'b10);
      wr(mk_byte(2'b10, 0, 1, 1, 3'd5));
      chk("R4 hold at second write", {track, hold}, 2'b01);
      chk("R5 power-only change clean", conv_bad, 0);
      chk("R10 internal clock", clk_int, 1);
      tick(12);
      chk("R6 ext int high", int_n, 1);
      tick(1);
      chk("R6 ext int low", int_n, 0);
      read_result("R4 ext result", 10'h2a5);

      // R5 unipolar bit changed on second write
      wr(mk_byte(2'b11, 1, 1, 1, 3'd5));
      wr(mk_byte(2'b11, 0, 1, 0, 3'd5));
      chk("R5 changed bit flagged", conv_bad, 1);
      chk("R10 external clock", clk_int, 0);
      tick(13);
      chk("R6 corrupted conv completes", int_n, 0);
      wr(mk_byte(2'b11, 0, 1, 1, 3'd0));
      chk("R8 int released by write", int_n, 1);
      chk("R5 flag cleared by write", conv_bad, 0);
      tick(20);

      // R7 abort during conversion
      target = 10'd100;
      wr(mk_byte(2'b11, 0, 0, 1, 3'd0));
      tick(8);
      chk("R7 converting before abort", hold, 1);
      target = 10'd777;
      wr(mk_byte(2'b11, 0, 0, 1, 3'd0));
      chk("R7 new acquisition", {track, hold, int_n}, 3'b101);
      tick(5);
      chk("R7 no int from aborted conv", int_n, 1);
      tick(11);
      chk("R7 new conv done", int_n, 0);
      read_result("R7 new result", 10'd777);

      // R9 power-down ignores requests, R10 keeps clock mode
      wr(mk_byte(2'b10, 0, 1, 1, 3'd1));
      tick(20);
      wr(mk_byte(2'b00, 0, 1, 1, 3'd1));
      chk("R9 full power-down code", pwr_state, 2'b00);
      chk("R10 clock kept in power-down", clk_int, 1);
      tick(20);
      chk("R9 no acquisition in power-down", {track, hold, int_n}, 3'b001);
      wr(mk_byte(2'b01, 1, 1, 1, 3'd1));
      tick(5);
      chk("R9 standby ignores request", {track, hold}, 2'b00);
      chk("R9 standby code", pwr_state, 2'b01);
      chk("R10 clock kept in standby", clk_int, 1);

      // random internal conversions
      for (int k = 0; k < 24; k++) begin
         logic [2:0] ad;
         logic sg, un, ck;
         ad = 3'($urandom); sg = 1'($urandom); un = 1'($urandom); ck = 1'($urandom);
         target = 10'($urandom);
         b = mk_byte({1'b1, ck}, 0, sg, un, ad);
         conv_int(b);
         chk("R1 uni_mode", uni_mode, un);
         chk("R1 pwr_state", pwr_state, {1'b1, ck});
         chk("R10 clock select", clk_int, !ck);
         chk("R2 mux_pos", mux_pos, ad);
         chk("R2 neg_com", neg_com, sg);
         if (!sg) chk("R2 mux_neg pair", mux_neg, ad ^ 3'd1);
         read_result("R6 random result", target);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule